// File: doc/BRIEF.md
# Signed Product Decimal Display Driver

This block takes the two's-complement product of two small signed operands and shows it on two seven-segment digits. The magnitude appears in decimal: the left digit holds the tens and the right digit holds the units. A negative result lights the decimal point of the left digit. A zero or positive result leaves that point dark.

A producer presents a product together with a one-cycle valid strobe. On the clock edge where valid is high, the block takes the absolute value of the product and converts it to BCD with a shift-and-add-three network. It then encodes both digits into segment patterns and registers them. Between strobes the display keeps the last value it showed, so the operand sources may change without any effect on it.

Top module: `sdisp_top`

## Requirements
- R1: While the synchronous active-low reset is held, both segment outputs are 8'hFF on the following edge, with every segment and both points dark.
- R2: Segment outputs are active-low. Bit 0 is segment A, bits 1 to 6 are B to G in order, and bit 7 is the decimal point. The active-high lit patterns for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex). Each output is the bitwise inverse of its pattern.
- R3: For any product of two OPER_W-bit signed operands, the tens output shows (|product| / 10) and the units output shows (|product| mod 10).
- R4: The tens output's bit 7 is 0 (lit) exactly when the shown product is negative.
- R5: A zero product is shown as positive, with the tens decimal point dark.
- R6: The units output's bit 7 is always 1 (dark).
- R7: A product presented with valid high appears on the outputs right after that same clock edge, a latency of one cycle.
- R8: While valid is low, both outputs hold their previous value whatever the product input does.
- R9: A magnitude below ten shows a 0 on the tens digit and is not blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prod_i | input | 2*OPER_W | Signed product to display |
| prod_vld_i | input | 1 | Capture strobe for prod_i |
| seg_tens_n_o | output | 8 | Tens digit segments, active low, with the sign on bit 7 |
| seg_units_n_o | output | 8 | Units digit segments, active low, bit 7 always dark |

## Verification
The bench builds the block with the default OPER_W of 4, which gives an 8-bit product input. It steps through all 256 operand pairs, so every reachable magnitude from 0 to 64 is checked with both signs. This covers the extremes 64 (from -8 times -8) and -56, zero reached through several different operand pairs, and every single-digit result. Runs of cycles with valid low are placed between the captures, and the product input is changed during them to show that the display holds.

// File: rtl/sdisp_pkg.sv
// Package: shared widths, bit positions and types for the signed
// product display. Assumes one seven-segment digit per 8-bit field.
package sdisp_pkg;
    localparam int SEG_W    = 8;   // A..G plus decimal point
    localparam int DP_BIT   = 7;   // decimal point position
    localparam int NIBBLE_W = 4;   // one BCD digit
    localparam int SHOW_DIG = 2;   // digits driven: units (0) and tens (1)

    typedef logic [NIBBLE_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0]    seg_t;

    localparam seg_t SEG_DARK = '1; // active-low: all off
endpackage

// File: rtl/sign_mag_split.sv
// Module: sign_mag_split
// Splits a two's-complement word into a sign flag and an unsigned
// magnitude of the same width. Assumes the input is never the most
// negative code of a width wider than the producer can reach.
module sign_mag_split #(
    parameter int W = 8
) (
    input  logic [W-1:0] val_i,
    output logic         neg_o,
    output logic [W-1:0] mag_o
);
    // Negate when the sign bit is set; zero therefore stays positive.
    always_comb begin
        neg_o = val_i[W-1];
        mag_o = neg_o ? (~val_i + W'(1)) : val_i;
    end
endmodule

// File: rtl/bcd_dabble.sv
// Module: bcd_dabble
// Purely combinational binary-to-BCD converter built as one
// shift-and-add-three stage per input bit. Assumes DIG_N digits are
// enough to hold the largest BIN_W-bit value.
module bcd_dabble
    import sdisp_pkg::*;
#(
    parameter int BIN_W = 8,
    parameter int DIG_N = 3
) (
    input  logic [BIN_W-1:0]          bin_i,
    output logic [DIG_N*NIBBLE_W-1:0] bcd_o
);
    localparam int BCD_W = DIG_N * NIBBLE_W;

    // Add three to every nibble that has reached five or more.
    function automatic logic [BCD_W-1:0] add3(input logic [BCD_W-1:0] v);
        logic [BCD_W-1:0] r;
        r = v;
        for (int d = 0; d < DIG_N; d++) begin
            if (v[d*NIBBLE_W +: NIBBLE_W] >= 4'd5)
                r[d*NIBBLE_W +: NIBBLE_W] = v[d*NIBBLE_W +: NIBBLE_W] + 4'd3;
        end
        return r;
    endfunction

    logic [BCD_W-1:0] stage [0:BIN_W];
    logic [BCD_W-1:0] adj   [0:BIN_W-1];

    assign stage[0] = '0;

    // One adjust-then-shift stage per bit, MSB first.
    for (genvar i = 0; i < BIN_W; i++) begin : g_stage
        assign adj[i]       = add3(stage[i]);
        assign stage[i + 1] = (adj[i] << 1) | BCD_W'(bin_i[BIN_W-1-i]);
    end

    assign bcd_o = stage[BIN_W];

    // Every produced nibble must be a legal decimal digit.
    for (genvar d = 0; d < DIG_N; d++) begin : g_chk
        always_comb begin
            AST_DIGIT_LEGAL: assert (bcd_o[d*NIBBLE_W +: NIBBLE_W] <= 4'd9) else $error("BCD nibble %0d out of range", d); // R3
        end
    end
endmodule

// File: rtl/seg_encode.sv
// Module: seg_encode
// Maps one BCD digit to active-low segments A..G (bits 0..6) and
// places the decimal point on bit 7. Codes above nine are blanked.
module seg_encode
    import sdisp_pkg::*;
(
    input  bcd_t digit_i,
    input  logic dp_on_i,
    output seg_t seg_n_o
);
    logic [6:0] lit;

    // Active-high lit pattern per decimal digit.
    always_comb begin
        unique case (digit_i)
            4'd0:    lit = 7'h3F;
            4'd1:    lit = 7'h06;
            4'd2:    lit = 7'h5B;
            4'd3:    lit = 7'h4F;
            4'd4:    lit = 7'h66;
            4'd5:    lit = 7'h6D;
            4'd6:    lit = 7'h7D;
            4'd7:    lit = 7'h07;
            4'd8:    lit = 7'h7F;
            4'd9:    lit = 7'h6F;
            default: lit = 7'h00;
        endcase
    end

    // Invert for common-anode drive.
    always_comb begin
        seg_n_o = {~dp_on_i, ~lit};
    end
endmodule

// File: rtl/sdisp_top.sv
// Module: sdisp_top
// Shows a signed product as two decimal digits: tens and units of the
// magnitude, with the sign on the tens decimal point. Assumes the
// product comes from two OPER_W-bit signed operands, so the magnitude
// never exceeds 2**(2*OPER_W-2) and fits in two digits for OPER_W <= 4.
module sdisp_top
    import sdisp_pkg::*;
#(
    parameter int OPER_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*OPER_W-1:0]   prod_i,
    input  logic                  prod_vld_i,
    output logic [SEG_W-1:0]      seg_tens_n_o,
    output logic [SEG_W-1:0]      seg_units_n_o
);
    localparam int PROD_W  = 2 * OPER_W;
    localparam int BCD_DIG = (PROD_W + 2) / 3;
    localparam int BCD_W   = BCD_DIG * NIBBLE_W;
    localparam int MAG_MAX = 1 << (PROD_W - 2);

    logic              neg;
    logic [PROD_W-1:0] mag;
    logic [BCD_W-1:0]  bcd;
    seg_t              seg_nxt [SHOW_DIG];

    sign_mag_split #(.W(PROD_W)) u_split (
        .val_i (prod_i),
        .neg_o (neg),
        .mag_o (mag)
    );

    bcd_dabble #(.BIN_W(PROD_W), .DIG_N(BCD_DIG)) u_bcd (
        .bin_i (mag),
        .bcd_o (bcd)
    );

    // One encoder per shown digit; only the tens digit carries the sign.
    for (genvar d = 0; d < SHOW_DIG; d++) begin : g_dig
        seg_encode u_enc (
            .digit_i (bcd[d*NIBBLE_W +: NIBBLE_W]),
            .dp_on_i ((d == SHOW_DIG - 1) ? neg : 1'b0),
            .seg_n_o (seg_nxt[d])
        );
    end

    // Output registers: blank in reset, load on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_tens_n_o  <= SEG_DARK;
            seg_units_n_o <= SEG_DARK;
        end else if (prod_vld_i) begin
            seg_tens_n_o  <= seg_nxt[SHOW_DIG-1];
            seg_units_n_o <= seg_nxt[0];
        end
    end

    AST_RESET_DARK: assert property (@(posedge clk) !rst_n |=> (seg_tens_n_o == SEG_DARK && seg_units_n_o == SEG_DARK)) else $error("outputs not dark after reset"); // R1
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !prod_vld_i |=> ($stable(seg_tens_n_o) && $stable(seg_units_n_o))) else $error("display changed without valid"); // R8
    AST_SIGN_POINT: assert property (@(posedge clk) disable iff (!rst_n) prod_vld_i |=> (seg_tens_n_o[DP_BIT] == !$past(prod_i[PROD_W-1]))) else $error("sign point wrong"); // R4
    AST_ZERO_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n) (prod_vld_i && prod_i == '0) |=> seg_tens_n_o[DP_BIT]) else $error("zero shown negative"); // R5
    AST_UNITS_POINT_DARK: assert property (@(posedge clk) disable iff (!rst_n) prod_vld_i |=> seg_units_n_o[DP_BIT]) else $error("units point lit"); // R6
    AST_MAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n) prod_vld_i |-> (int'(mag) <= MAG_MAX)) else $error("product outside operand range"); // R3

    if (BCD_DIG > SHOW_DIG) begin : g_hi_chk
        AST_NO_HUNDREDS: assert property (@(posedge clk) disable iff (!rst_n) prod_vld_i |-> (bcd[BCD_W-1:SHOW_DIG*NIBBLE_W] == '0)) else $error("magnitude needs a third digit"); // R3
    end
endmodule

// File: tb/sdisp_top_tb.sv
module sdisp_top_tb;
    localparam int OPER_W = 4;
    localparam int PROD_W = 2 * OPER_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PROD_W-1:0] prod = '0;
    logic              vld = 1'b0;
    logic [7:0]        seg_tens, seg_units;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sdisp_top #(.OPER_W(OPER_W)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .prod_i        (prod),
        .prod_vld_i    (vld),
        .seg_tens_n_o  (seg_tens),
        .seg_units_n_o (seg_units)
    );

    // Lit pattern per digit, taken from R2.
    function automatic logic [6:0] lit_of(input int d);
        logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                               7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
        return t[d];
    endfunction

    // Reference model state, updated each rising edge.
    logic [7:0] exp_tens = 8'hFF, exp_units = 8'hFF;
    string      ctx = "R1";
    int         exp_val = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_tens = 8'hFF;
            exp_units = 8'hFF;
            ctx = "R1";
        end else if (vld) begin
            int p, m;
            p = $signed(prod);
            m = (p < 0) ? -p : p;
            exp_val = p;
            exp_tens = {(p < 0) ? 1'b0 : 1'b1, ~lit_of(m / 10)};
            exp_units = {1'b1, ~lit_of(m % 10)};
            if (m < 10) ctx = "R2 R3 R7 R9";
            else ctx = "R2 R3 R7";
        end else begin
            ctx = "R8";
        end
    end

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s (product %0d): actual %h expected %h", req, what, exp_val, act, exp);
        end
    endtask

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            check(ctx, "tens digit", {1'b0, seg_tens[6:0]}, {1'b0, exp_tens[6:0]});
            check(ctx, "units digit", {1'b0, seg_units[6:0]}, {1'b0, exp_units[6:0]});
            if (ctx == "R1" || ctx == "R8") begin
                check(ctx, "tens point", {7'd0, seg_tens[7]}, {7'd0, exp_tens[7]});
            end else if (exp_val == 0) begin
                check("R5", "tens point", {7'd0, seg_tens[7]}, {7'd0, exp_tens[7]});
            end else begin
                check("R4", "tens point", {7'd0, seg_tens[7]}, {7'd0, exp_tens[7]});
            end
            check("R6", "units point", {7'd0, seg_units[7]}, 8'd1);
        end
    end

    task automatic show(input int a, input int b);
        @(negedge clk);
        prod = PROD_W'(a * b);
        vld = 1'b1;
    endtask

    task automatic idle(input int n, input logic [PROD_W-1:0] junk);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            vld = 1'b0;
            prod = junk + PROD_W'(k * 37);
        end
    endtask

    initial begin
        // R1: reset for a few cycles with valid high and a nonzero product.
        prod = 8'h12;
        vld = 1'b1;
        repeat (3) @(negedge clk);
        vld = 1'b0;
        rst_n = 1'b1;
        idle(2, 8'h55);
        // Sample operand pairs: 6*3, -8*2, 6*-2, -4*-7.
        show(6, 3);
        show(-8, 2);
        show(6, -2);
        show(-4, -7);
        idle(4, 8'hC0);
        // Full sweep of 4-bit signed operands, with hold gaps.
        for (int a = -8; a < 8; a++) begin
            for (int b = -8; b < 8; b++) begin
                show(a, b);
            end
            idle(3, PROD_W'(a));
        end
        // Zero from a negative operand, then the extremes.
        show(0, -5);
        show(-8, -8);
        show(-8, 7);
        idle(3, 8'hA5);
        // Reset mid-run blanks the display again.
        @(negedge clk);
        rst_n = 1'b0;
        vld = 1'b1;
        prod = 8'hF0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        vld = 1'b0;
        idle(3, 8'h07);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule